// File: doc/BRIEF.md
# Blank check verifier

This block decides whether a device reads back as erased. A read sequencer outside the block feeds it one byte per cycle. Each byte comes with its 22-bit address and a 2-bit region tag. The block compares each byte with the value an erased cell of that region must show, and it keeps a single verdict.

In the code, data EEPROM and ID regions every erased byte is all ones. Configuration bytes differ, because their reserved bits read as zero. For that reason each configuration byte is compared, byte by byte, against its own entry in a small expected-value table that can be loaded through a write port. The two device ID addresses are skipped.

The first mismatch ends the check. The failing address and the byte that was read are frozen until the block is cleared. A pass is reported only when the end-of-stream strobe arrives and no mismatch has been seen.

Top module: `blank_check_verifier`

## Requirements
- R1: After reset, `pass`, `fail`, `fail_addr` and `fail_data` are all zero, and every configuration table entry is FFh.
- R2: A valid byte with region tag 0 (code), 1 (data EEPROM) or 2 (ID) that is not FFh sets `fail` at the next clock edge. At the same edge it latches `fail_addr` and `fail_data`.
- R3: A valid byte with region tag 3 (configuration) is compared with table entry `in_addr[IDX_W-1:0]`. That entry is written with `cfg_we`/`cfg_idx`/`cfg_val` and takes effect from the next cycle.
- R4: Bytes at addresses 3FFFFEh and 3FFFFFh never cause a failure, whatever their region or data.
- R5: Once `fail` or `pass` is set, further bytes and strobes change neither the verdict nor `fail_addr`/`fail_data` until `clr`.
- R6: `stream_end` sets `pass` at the next edge only if no mismatch was seen. A mismatch presented in the same cycle as `stream_end` yields `fail` instead.
- R7: `clr` zeroes `pass`, `fail`, `fail_addr` and `fail_data` at the next edge, takes priority over other inputs in that cycle, and leaves the configuration table unchanged.
- R8: With `in_valid` low, the data, address and region inputs have no effect.
- R9: `pass` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start a new check: clear verdict and latched values |
| in_valid | input | 1 | Address/data pair is valid this cycle |
| in_addr | input | ADDR_W | Byte address |
| in_data | input | 8 | Byte read back |
| in_region | input | 2 | 0 code, 1 data EEPROM, 2 ID, 3 configuration |
| stream_end | input | 1 | Last pair has been delivered |
| cfg_we | input | 1 | Write configuration expected value |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_val | input | 8 | Expected configuration byte |
| pass | output | 1 | Device is blank (held until clear) |
| fail | output | 1 | Mismatch seen (held until clear) |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | 8 | Byte read at the first mismatch |

## Verification
Directed streams cover the following cases:
- A fully erased device across all four regions, which must reach a pass.
- A single bad code byte followed by a second bad byte, which separates first-failure latching from last-failure latching.
- Zero bytes at the two ID addresses, which shows whether the exclusion holds in every region.
- Bad data with `in_valid` low, and a mismatch coinciding with `stream_end`.

Random streams draw a fresh configuration table and mixed regions for each trial, and inject at most a few corrupted bytes. Because the configuration entries are not FFh, these streams show whether the comparison picks the table entry or the all-ones value for each region. Bytes that arrive after a verdict test the freeze.

// File: rtl/blank_check_verifier.sv
module blank_check_verifier #(
  parameter int ADDR_W = 22,
  parameter int CFG_N = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR_A = 22'h3FFFFE,
  parameter logic [ADDR_W-1:0] ID_ADDR_B = 22'h3FFFFF,
  localparam int IDX_W = $clog2(CFG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_data,
  input  logic [1:0]        in_region,
  input  logic              stream_end,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_val,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data
);

  logic [7:0] cfg_tab [CFG_N];

  wire       skip    = (in_addr == ID_ADDR_A) || (in_addr == ID_ADDR_B);
  wire [7:0] want    = (in_region == 2'd3) ? cfg_tab[in_addr[IDX_W-1:0]] : 8'hFF;
  wire       settled = pass | fail;
  wire       miss    = in_valid && !settled && !skip && (in_data != want);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_N; i++) cfg_tab[i] <= 8'hFF;
    end else if (cfg_we) begin
      cfg_tab[cfg_idx] <= cfg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else if (clr) begin
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else if (miss) begin
      fail      <= 1'b1;
      fail_addr <= in_addr;
      fail_data <= in_data;
    end else if (stream_end && !settled) begin
      pass      <= 1'b1;
    end
  end

endmodule

module blank_check_verifier_chk #(
  parameter int ADDR_W = 22,
  parameter logic [ADDR_W-1:0] ID_ADDR_A = 22'h3FFFFE,
  parameter logic [ADDR_W-1:0] ID_ADDR_B = 22'h3FFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              stream_end,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [7:0]        fail_data
);
  wire id_hit = (in_addr == ID_ADDR_A) || (in_addr == ID_ADDR_B);

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail)); // R9
  AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clr |=> fail && $stable(fail_addr) && $stable(fail_data)); // R5
  AST_PASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pass && !clr |=> pass); // R5
  AST_ID_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && id_hit && !fail && !clr |=> !fail); // R4
  AST_PASS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(stream_end)); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pass && !fail && fail_addr == '0 && fail_data == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !stream_end && !clr |=> $stable(fail) && $stable(pass)); // R8
endmodule

bind blank_check_verifier blank_check_verifier_chk #(
  .ADDR_W(ADDR_W), .ID_ADDR_A(ID_ADDR_A), .ID_ADDR_B(ID_ADDR_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_addr(in_addr),
  .stream_end(stream_end), .pass(pass), .fail(fail),
  .fail_addr(fail_addr), .fail_data(fail_data)
);

// File: tb/sim_blank_check_verifier.sv
`timescale 1ns/1ps
module sim_blank_check_verifier;
  localparam int AW = 22;
  localparam int CN = 16;
  localparam int IW = $clog2(CN);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, stream_end = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [7:0] in_data = '0, cfg_val = '0;
  logic [1:0] in_region = '0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic pass, fail;
  logic [AW-1:0] fail_addr;
  logic [7:0] fail_data;

  blank_check_verifier u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] m_cfg [CN];
  logic m_pass, m_fail;
  logic [AW-1:0] m_addr;
  logic [7:0] m_data;

  function automatic logic [7:0] expect_of(logic [1:0] r, logic [AW-1:0] a);
    return (r == 2'd3) ? m_cfg[a[IW-1:0]] : 8'hFF;
  endfunction

  function automatic logic is_id(logic [AW-1:0] a);
    return a == 22'h3FFFFE || a == 22'h3FFFFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    chk({req, " pass"}, 32'(pass), 32'(m_pass));
    chk({req, " fail"}, 32'(fail), 32'(m_fail));
    chk({req, " fail_addr"}, 32'(fail_addr), 32'(m_addr));
    chk({req, " fail_data"}, 32'(fail_data), 32'(m_data));
  endtask

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic step(string req, logic v, logic [AW-1:0] a, logic [7:0] d,
                      logic [1:0] r, logic se, logic c);
    in_valid = v; in_addr = a; in_data = d; in_region = r; stream_end = se; clr = c;
    if (c) begin
      m_pass = 0; m_fail = 0; m_addr = '0; m_data = '0;
    end else if (v && !m_pass && !m_fail && !is_id(a) && d != expect_of(r, a)) begin
      m_fail = 1; m_addr = a; m_data = d;
    end else if (se && !m_pass && !m_fail) begin
      m_pass = 1;
    end
    @(negedge clk);
    in_valid = 0; stream_end = 0; clr = 0;
    cmp_all(req);
  endtask

  task automatic wr_cfg(logic [IW-1:0] i, logic [7:0] v);
    cfg_we = 1; cfg_idx = i; cfg_val = v;
    @(negedge clk);
    cfg_we = 0;
    m_cfg[i] = v;
  endtask

  task automatic rand_pair(output logic [AW-1:0] a, output logic [1:0] r);
    r = 2'($urandom_range(0, 3));
    case (r)
      2'd0: a = AW'($urandom_range(0, 22'h1FFFFF));
      2'd1: a = AW'(22'hF00000 + $urandom_range(0, 1023));
      2'd2: a = AW'(22'h200000 + $urandom_range(0, 7));
      default: a = AW'(22'h300000 + $urandom_range(0, CN - 1));
    endcase
    if ($urandom_range(0, 19) == 0) a = $urandom_range(0, 1) ? 22'h3FFFFE : 22'h3FFFFF;
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [1:0] r;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < CN; i++) m_cfg[i] = 8'hFF;
    m_pass = 0; m_fail = 0; m_addr = '0; m_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1 reset");
    // table reset to FF: cfg byte FF must not fail
    step("R1 cfg table reset", 1, 22'h300005, 8'hFF, 2'd3, 0, 0);

    // erased device across regions with programmed cfg table
    wr_cfg(0, 8'h27); wr_cfg(1, 8'h0F); wr_cfg(2, 8'h00);
    step("R7 clr", 0, '0, 8'h00, 2'd0, 0, 1);
    step("R2 code FF", 1, 22'h000010, 8'hFF, 2'd0, 0, 0);
    step("R2 eeprom FF", 1, 22'hF00003, 8'hFF, 2'd1, 0, 0);
    step("R2 id FF", 1, 22'h200001, 8'hFF, 2'd2, 0, 0);
    step("R3 cfg match", 1, 22'h300000, 8'h27, 2'd3, 0, 0);
    step("R3 cfg match", 1, 22'h300001, 8'h0F, 2'd3, 0, 0);
    step("R8 invalid ignored", 0, 22'h000011, 8'h00, 2'd0, 0, 0);
    step("R4 id addr ignored", 1, 22'h3FFFFE, 8'h00, 2'd3, 0, 0);
    step("R4 id addr ignored", 1, 22'h3FFFFF, 8'h12, 2'd0, 0, 0);
    step("R6 pass on end", 0, '0, 8'h00, 2'd0, 1, 0);
    step("R5 pass frozen", 1, 22'h000020, 8'h00, 2'd0, 0, 0);
    chk("R6 pass set", 32'(pass), 32'd1);

    // first failure latched
    step("R7 clr after pass", 0, '0, 8'h00, 2'd0, 0, 1);
    step("R3 cfg FF vs 27 fails", 1, 22'h300000, 8'hFF, 2'd3, 0, 0);
    chk("R3 cfg mismatch", 32'(fail), 32'd1);
    step("R7 clr", 0, '0, 8'h00, 2'd0, 0, 1);
    step("R7 table kept", 1, 22'h300002, 8'h00, 2'd3, 0, 0);
    step("R2 code bad", 1, 22'h000123, 8'hFE, 2'd0, 0, 0);
    chk("R2 fail_addr", 32'(fail_addr), 32'h123);
    step("R5 second bad held", 1, 22'h000124, 8'h00, 2'd1, 0, 0);
    step("R6 no pass after fail", 0, '0, 8'h00, 2'd0, 1, 0);
    step("R7 clr priority", 1, 22'h000200, 8'h00, 2'd0, 1, 1);
    step("R6 miss with end", 1, 22'h200003, 8'h7F, 2'd2, 1, 0);
    chk("R6 fail wins", 32'(fail), 32'd1);

    // constrained random trials
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < CN; i++)
        if ($urandom_range(0, 2) == 0) wr_cfg(IW'(i), 8'($urandom));
      step("R7 clr", 0, '0, 8'h00, 2'd0, 0, 1);
      for (int k = 0; k < 40; k++) begin
        rand_pair(a, r);
        d = expect_of(r, a);
        if ($urandom_range(0, 99) < 2) d = d ^ 8'(1 << $urandom_range(0, 7));
        step("R2/R3 random", $urandom_range(0, 7) != 0, a, d, r, 0, 0);
      end
      step("R6 random end", 0, '0, 8'h00, 2'd0, 1, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule